// File: doc/BRIEF.md
# Multi-Channel Interprocessor Mailbox

This block lets processors on a chip hand short messages to one another. It holds a set of one-way channels, four by default and up to thirty-two. Every channel owns a 64-byte window on a simple register bus that completes each access in a single cycle. A sender claims an idle channel by writing its own one-hot acknowledge bit into the channel's owner register and reading it back. It then picks the receiver interrupt vectors, unmasks the ones it wants, fills up to eight message words and issues a send.

The send latches the selected, unmasked vectors as pending receiver interrupts. In automatic-acknowledge mode the channel then reports itself acknowledged and pulses the owner's acknowledge line one cycle later, with no action from the receiver. A global key-protected lock keeps stray writes away from the channel registers. The lock is engaged out of reset.

Top module: `mbox_core`

## Requirements
- R1: Channel c occupies bus addresses c*0x40 to c*0x40+0x3f. Word offsets are: owner 0x00, destination 0x04, destination clear 0x08, pending status 0x0c, mode 0x10, interrupt mask 0x14, pending clear 0x18, send 0x1c, and message words 0 to 7 at 0x20 to 0x3c. Message words read back as written. Reads of 0x08, 0x18, 0x1c and of channels past the last read zero.
- R2: After reset the lock is engaged, every owner, destination and pending register is zero, every mask is all ones, every mode register reads 0x10, and both interrupt vectors are zero.
- R3: Writing a value with exactly one bit set to the owner register of an idle channel (owner zero) stores it, and a read returns it. A value without exactly one bit set leaves the channel idle.
- R4: An owner write to a channel that already has an owner changes nothing, unless it is the release of R10.
- R5: A destination write ORs its bits into the destination register. A destination-clear write clears the bits written as one. A mask write replaces the mask, where 1 masks a vector. rxIrq is the OR over all channels of pending AND NOT mask.
- R6: A send write whose value equals the current non-zero owner ORs destination AND NOT mask into pending. The result is visible in the cycle after the write. Other send values are ignored. A pending-clear write clears the pending bits written as one.
- R7: Mode bit 0 selects automatic acknowledge. When it is set, one cycle after pending is raised by a send, mode bit 7 reads 1 and ackIrq carries the owner bit for exactly one cycle. When it is clear, no acknowledge occurs. Mode bit 4 reads 1 while the channel is idle.
- R8: The lock register at 0xa00 reads 0 when open and 1 when engaged. Writing 0x1acce551 opens it, and writing any other value engages it.
- R9: While the lock is engaged, writes to channel registers have no effect.
- R10: Writing the current owner bit to the owner register while the mask is all ones returns the channel to idle: owner 0, mode bit 7 cleared. With any vector unmasked, the same write changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte address of the access |
| busWe | input | 1 | Write strobe for the current cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, same cycle |
| rxIrq | output | 32 | Receiver interrupt vectors, OR of all channels |
| ackIrq | output | 32 | Sender acknowledge vectors, one-cycle pulses |

## Verification
The hardest case to reach is the one-cycle window between a send and its automatic acknowledge. The pending interrupt must already be visible there while the acknowledge has not yet fired. Reaching it takes the whole protocol in order: unlock, claim, destination, unmask, mode and send. The bench follows every step with a behavioural model checked on every clock. Two other cases are exercised on their own. A release attempt made with an unmasked vector is refused. After a relock, writes are ignored, and the lock and owner reads show that nothing moved.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int REG_W = 32;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] LOCK_ADDR = 12'hA00;
  localparam logic [REG_W-1:0] LOCK_KEY = 32'h1acce551;

  // word index within a channel window (address bits 4:2, bit 5 clear)
  localparam logic [2:0] W_OWN  = 3'd0;
  localparam logic [2:0] W_DST  = 3'd1;
  localparam logic [2:0] W_DCLR = 3'd2;
  localparam logic [2:0] W_PEND = 3'd3;
  localparam logic [2:0] W_MODE = 3'd4;
  localparam logic [2:0] W_MASK = 3'd5;
  localparam logic [2:0] W_ICLR = 3'd6;
  localparam logic [2:0] W_SEND = 3'd7;

  typedef struct packed {
    logic own;
    logic dst;
    logic dclr;
    logic mode;
    logic mask;
    logic iclr;
    logic send;
    logic data;
    logic [2:0] word;
  } chStrobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int IDX_W = ADDR_W - 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic [REG_W-1:0]     busWdata,
  output chStrobe_t [NUM_CH-1:0] strobes,
  output logic                 lockOpen,
  output logic [SEL_W-1:0]     rdChan,
  output logic [3:0]           rdWord,
  output logic                 rdInRange,
  output logic                 rdIsLock
);
  logic [IDX_W-1:0] chIdx;
  logic isLock;
  logic chWe;

  assign chIdx     = busAddr[ADDR_W-1:6];
  assign isLock    = (busAddr == LOCK_ADDR);
  assign rdInRange = (32'(chIdx) < NUM_CH) && !isLock;
  assign rdIsLock  = isLock;
  assign rdChan    = chIdx[SEL_W-1:0];
  assign rdWord    = busAddr[5:2];
  assign chWe      = busWe && lockOpen && rdInRange;

  // lock register: key opens, anything else closes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockOpen <= 1'b0;
    else if (busWe && isLock) lockOpen <= (busWdata == LOCK_KEY);
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      strobes[i] = '0;
      strobes[i].word = busAddr[4:2];
      if (chWe && chIdx == IDX_W'(i)) begin
        if (busAddr[5]) strobes[i].data = 1'b1;
        else begin
          case (busAddr[4:2])
            W_OWN:   strobes[i].own  = 1'b1;
            W_DST:   strobes[i].dst  = 1'b1;
            W_DCLR:  strobes[i].dclr = 1'b1;
            W_MODE:  strobes[i].mode = 1'b1;
            W_MASK:  strobes[i].mask = 1'b1;
            W_ICLR:  strobes[i].iclr = 1'b1;
            W_SEND:  strobes[i].send = 1'b1;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IRQ_W = 32,
  parameter int MSG_WORDS = 8,
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  chStrobe_t [NUM_CH-1:0]  strobes,
  input  logic [REG_W-1:0]        busWdata,
  input  logic                    lockOpen,
  input  logic [SEL_W-1:0]        rdChan,
  input  logic [3:0]              rdWord,
  input  logic                    rdInRange,
  input  logic                    rdIsLock,
  output logic [REG_W-1:0]        busRdata,
  output logic [IRQ_W-1:0]        rxIrq,
  output logic [IRQ_W-1:0]        ackIrq,
  output logic [NUM_CH*IRQ_W-1:0] chOwner,
  output logic [NUM_CH*IRQ_W-1:0] chPend
);
  logic [IRQ_W-1:0] chRx   [NUM_CH];
  logic [IRQ_W-1:0] chAckV [NUM_CH];
  logic [REG_W-1:0] chRead [NUM_CH];
  logic [IRQ_W-1:0] wv;

  assign wv = busWdata[IRQ_W-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [IRQ_W-1:0] owner, dst, mask, pend;
    logic autoMode, ackFlag, armAck, ackPulse;
    logic [REG_W-1:0] msg [MSG_WORDS];
    logic claimOk, releaseOk, sendOk;
    chStrobe_t st;

    assign st        = strobes[g];
    assign claimOk   = st.own && (owner == '0) && $onehot(wv);
    assign releaseOk = st.own && (owner != '0) && (wv == owner) && (&mask);
    assign sendOk    = st.send && (owner != '0) && (wv == owner);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        owner <= '0; dst <= '0; mask <= '1; pend <= '0;
        autoMode <= 1'b0; ackFlag <= 1'b0; armAck <= 1'b0; ackPulse <= 1'b0;
      end else begin
        ackPulse <= armAck;
        armAck   <= 1'b0;
        if (armAck) ackFlag <= 1'b1;
        if (claimOk) owner <= wv;
        if (releaseOk) begin
          owner <= '0; ackFlag <= 1'b0; armAck <= 1'b0;
        end
        if (st.dst)  dst <= dst | wv;
        if (st.dclr) dst <= dst & ~wv;
        if (st.mask) mask <= wv;
        if (st.mode) autoMode <= busWdata[0];
        if (st.iclr) pend <= pend & ~wv;
        if (sendOk) begin
          pend    <= pend | (dst & ~mask);
          ackFlag <= 1'b0;
          armAck  <= autoMode;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (st.data) msg[st.word] <= busWdata;
    end

    always_comb begin
      chRead[g] = '0;
      if (rdWord[3]) chRead[g] = msg[rdWord[2:0]];
      else begin
        case (rdWord[2:0])
          W_OWN:  chRead[g] = REG_W'(owner);
          W_DST:  chRead[g] = REG_W'(dst);
          W_PEND: chRead[g] = REG_W'(pend);
          W_MODE: chRead[g] = REG_W'({ackFlag, 2'b00, (owner == '0), 3'b000, autoMode});
          W_MASK: chRead[g] = REG_W'(mask);
          default: chRead[g] = '0;
        endcase
      end
    end

    assign chRx[g]   = pend & ~mask;
    assign chAckV[g] = ackPulse ? owner : '0;
    assign chOwner[g*IRQ_W +: IRQ_W] = owner;
    assign chPend[g*IRQ_W +: IRQ_W]  = pend;
  end

  always_comb begin
    rxIrq  = '0;
    ackIrq = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      rxIrq  = rxIrq | chRx[i];
      ackIrq = ackIrq | chAckV[i];
    end
  end

  always_comb begin
    if (rdIsLock)       busRdata = {{(REG_W-1){1'b0}}, !lockOpen};
    else if (rdInRange) busRdata = chRead[rdChan];
    else                busRdata = '0;
  end
endmodule

// File: rtl/mbox_core.sv
module mbox_core
  import mbox_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IRQ_W = 32,
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [11:0]       busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [IRQ_W-1:0]  rxIrq,
  output logic [IRQ_W-1:0]  ackIrq
);
  chStrobe_t [NUM_CH-1:0] strobes;
  logic lockOpen;
  logic [SEL_W-1:0] rdChan;
  logic [3:0] rdWord;
  logic rdInRange, rdIsLock;
  logic [NUM_CH*IRQ_W-1:0] chOwner, chPend;

  mbox_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .strobes(strobes), .lockOpen(lockOpen), .rdChan(rdChan), .rdWord(rdWord),
    .rdInRange(rdInRange), .rdIsLock(rdIsLock)
  );

  mbox_dpath #(.NUM_CH(NUM_CH), .IRQ_W(IRQ_W), .MSG_WORDS(8)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWdata(busWdata), .lockOpen(lockOpen),
    .rdChan(rdChan), .rdWord(rdWord), .rdInRange(rdInRange), .rdIsLock(rdIsLock),
    .busRdata(busRdata), .rxIrq(rxIrq), .ackIrq(ackIrq), .chOwner(chOwner), .chPend(chPend)
  );
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker
  import mbox_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IRQ_W = 32
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [11:0]             busAddr,
  input logic                    busWe,
  input logic [31:0]             busRdata,
  input logic [IRQ_W-1:0]        rxIrq,
  input logic [IRQ_W-1:0]        ackIrq,
  input logic                    lockOpen,
  input logic [NUM_CH*IRQ_W-1:0] chOwner,
  input logic [NUM_CH*IRQ_W-1:0] chPend
);
  assert_lock_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == LOCK_ADDR) |-> ((busRdata == 32'd0) == lockOpen));

  assert_locked_ignore_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && !lockOpen && busAddr != LOCK_ADDR) |=> ($stable(chOwner) && $stable(chPend)));

  assert_ack_after_send_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ackIrq != '0) |-> $past(busWe, 2));

  assert_rx_from_pending_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxIrq != '0) |-> (chPend != '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_own
    assert_owner_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(chOwner[g*IRQ_W +: IRQ_W]));
    assert_owner_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
      (chOwner[g*IRQ_W +: IRQ_W] != '0) |=>
        ((chOwner[g*IRQ_W +: IRQ_W] == $past(chOwner[g*IRQ_W +: IRQ_W])) ||
         (chOwner[g*IRQ_W +: IRQ_W] == '0)));
  end
endmodule

bind mbox_core mbox_checker #(.NUM_CH(NUM_CH), .IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRdata(busRdata),
  .rxIrq(rxIrq), .ackIrq(ackIrq), .lockOpen(lockOpen), .chOwner(chOwner), .chPend(chPend)
);

// File: tb/sim_mbox_core.sv
`timescale 1ns/1ps
module sim_mbox_core;
  localparam int NCH = 4;
  localparam logic [31:0] KEY = 32'h1acce551;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata, rxIrq, ackIrq;

  always #5 clk = ~clk;

  mbox_core #(.NUM_CH(NCH), .IRQ_W(32)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .rxIrq(rxIrq), .ackIrq(ackIrq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference model
  logic [31:0] mOwn [NCH], mDst [NCH], mMask [NCH], mPend [NCH];
  logic [31:0] mMsg [NCH][8];
  bit mAuto [NCH], mAck [NCH], mArm [NCH], mPulse [NCH];
  bit mOpen;

  always @(posedge clk) begin
    if (!rstN) begin
      mOpen = 0;
      for (int c = 0; c < NCH; c++) begin
        mOwn[c] = 0; mDst[c] = 0; mMask[c] = '1; mPend[c] = 0;
        mAuto[c] = 0; mAck[c] = 0; mArm[c] = 0; mPulse[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        mPulse[c] = mArm[c];
        if (mArm[c]) mAck[c] = 1;
        mArm[c] = 0;
      end
      if (busWe) begin
        if (busAddr == 12'hA00) mOpen = (busWdata == KEY);
        else if (mOpen && int'(busAddr / 64) < NCH) begin
          int c, w;
          c = int'(busAddr / 64);
          w = int'(busAddr % 64) / 4;
          if (w >= 8) mMsg[c][w-8] = busWdata;
          else case (w)
            0: if (mOwn[c] == 0) begin
                 if ($countones(busWdata) == 1) mOwn[c] = busWdata;
               end else if (busWdata == mOwn[c] && mMask[c] == '1) begin
                 mOwn[c] = 0; mAck[c] = 0; mArm[c] = 0;
               end
            1: mDst[c] = mDst[c] | busWdata;
            2: mDst[c] = mDst[c] & ~busWdata;
            4: mAuto[c] = busWdata[0];
            5: mMask[c] = busWdata;
            6: mPend[c] = mPend[c] & ~busWdata;
            7: if (mOwn[c] != 0 && busWdata == mOwn[c]) begin
                 mPend[c] = mPend[c] | (mDst[c] & ~mMask[c]);
                 mAck[c] = 0; mArm[c] = mAuto[c];
               end
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [31:0] mRead(logic [11:0] a);
    int c, w;
    if (a == 12'hA00) return mOpen ? 32'd0 : 32'd1;
    c = int'(a / 64);
    w = int'(a % 64) / 4;
    if (c >= NCH) return 0;
    if (w >= 8) return mMsg[c][w-8];
    case (w)
      0: return mOwn[c];
      1: return mDst[c];
      3: return mPend[c];
      4: return {24'd0, mAck[c], 2'b00, (mOwn[c] == 0), 3'b000, mAuto[c]};
      5: return mMask[c];
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] mRx();
    logic [31:0] v = 0;
    for (int c = 0; c < NCH; c++) v = v | (mPend[c] & ~mMask[c]);
    return v;
  endfunction

  function automatic logic [31:0] mAckOut();
    logic [31:0] v = 0;
    for (int c = 0; c < NCH; c++) if (mPulse[c]) v = v | mOwn[c];
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll();
    chk("R1 model read", busRdata, mRead(busAddr));
    chk("R5 model rxIrq", rxIrq, mRx());
    chk("R7 model ackIrq", ackIrq, mAckOut());
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); checkAll();
    busAddr = a; busWe = 1'b1; busWdata = d;
  endtask

  task automatic idle();
    @(negedge clk); checkAll();
    busWe = 1'b0; busWdata = 0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk); checkAll();
    busAddr = a; busWe = 1'b0; busWdata = 0;
    #1 chk(tag, busRdata, exp);
  endtask

  function automatic logic [11:0] ra(int c, int off);
    return 12'(c * 64 + off);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R2 reset state
    rd(12'hA00, 32'd1, "R2 lock engaged");
    rd(ra(0, 16), 32'h10, "R2 mode idle");
    rd(ra(3, 20), 32'hffffffff, "R2 mask all ones");
    chk("R2 rxIrq zero", rxIrq, 0);
    // R9 locked writes ignored
    wr(ra(0, 0), 32'h4);
    wr(ra(0, 32), 32'hdead);
    rd(ra(0, 0), 32'd0, "R9 owner unchanged while locked");
    // R8 unlock
    wr(12'hA00, KEY);
    rd(12'hA00, 32'd0, "R8 lock open");
    // R3 claim / R4 busy
    wr(ra(1, 0), 32'h8);
    rd(ra(1, 0), 32'h8, "R3 claim reads back");
    wr(ra(1, 0), 32'h20);
    rd(ra(1, 0), 32'h8, "R4 second claim ignored");
    wr(ra(2, 0), 32'h3);
    rd(ra(2, 0), 32'h0, "R3 non-one-hot rejected");
    // R5 destination and mask, R1 message words
    wr(ra(1, 4), 32'h4);
    wr(ra(1, 4), 32'h200);
    wr(ra(1, 8), 32'h200);
    rd(ra(1, 4), 32'h4, "R5 dst set then cleared");
    wr(ra(1, 20), ~32'h4);
    for (int i = 0; i < 8; i++) wr(ra(1, 32 + 4 * i), 32'hA000 + i);
    rd(ra(1, 60), 32'hA007, "R1 last message word");
    rd(ra(1, 32), 32'hA000, "R1 first message word");
    rd(ra(1, 8), 32'h0, "R1 clear register reads zero");
    rd(12'h3C0, 32'h0, "R1 out-of-range channel");
    wr(ra(1, 16), 32'h1);
    // R6 wrong send value ignored
    wr(ra(1, 28), 32'h20);
    idle();
    chk("R6 wrong send ignored", rxIrq, 0);
    // R6/R7 auto-ack send
    wr(ra(1, 28), 32'h8);
    idle();
    chk("R6 rxIrq raised", rxIrq, 32'h4);
    chk("R7 no ack in send+1 cycle", ackIrq, 0);
    idle();
    chk("R7 ack pulse owner bit", ackIrq, 32'h8);
    rd(ra(1, 16), 32'h81, "R7 mode shows ack");
    chk("R7 ack pulse over", ackIrq, 0);
    rd(ra(1, 12), 32'h4, "R6 pending status");
    wr(ra(1, 24), 32'h4);
    idle();
    chk("R6 pending cleared", rxIrq, 0);
    // R7 manual mode on channel 2
    wr(ra(2, 0), 32'h2);
    wr(ra(2, 4), 32'h1);
    wr(ra(2, 20), 32'h0);
    wr(ra(2, 28), 32'h2);
    idle();
    chk("R6 ch2 rxIrq", rxIrq, 32'h1);
    idle(); idle();
    chk("R7 no ack in manual mode", ackIrq, 0);
    rd(ra(2, 16), 32'h0, "R7 manual mode no ack flag");
    // R10 release
    wr(ra(2, 0), 32'h2);
    rd(ra(2, 0), 32'h2, "R10 release refused when unmasked");
    wr(ra(1, 20), 32'hffffffff);
    wr(ra(1, 0), 32'h8);
    rd(ra(1, 16), 32'h11, "R10 released to idle");
    // R8 relock, R9
    wr(12'hA00, 32'h1);
    rd(12'hA00, 32'd1, "R8 relocked");
    wr(ra(1, 0), 32'h1);
    wr(ra(2, 24), 32'h1);
    rd(ra(1, 0), 32'h0, "R9 claim ignored when locked");
    chk("R9 pending unchanged", rxIrq, 32'h1);
    idle(); idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule